// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the coherence state of every line in a small private write-back cache. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. The block sits between the local core's request port and a shared snoop bus. Local reads and writes complete in the same cycle when the line's state allows it. Otherwise the block raises one bus request and stalls the core until a grant or a refusal arrives. If the core keeps its request asserted, the request is then retried.

Remote snoops arrive every cycle without a handshake. A snoop that finds a dirty line produces a one-cycle write-back pulse that carries the line's data. A read snoop demotes the line to Shared, and an invalidate snoop drops it. An ownership upgrade from Shared can be refused by the other caches. In that case the line stays Shared and the held write tries again, so the block never assumes that an upgrade succeeds.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and bus_req_valid and wb_valid are low, so the first read of any line stalls (core_ready low) and raises a shared-read request.
- R2: A read of a line in Shared, Exclusive or Modified gives core_ready high in the same cycle, with core_rdata equal to the line's data and no bus request raised.
- R3: A read miss raises bus_req_valid with bus_req_own=0 and bus_req_line set to the line, in the cycle after the request. The request is held until bus_grant or bus_refuse. A grant fills the line with bus_fill_data, in Exclusive if bus_shared is low and in Shared otherwise.
- R4: A write to an Exclusive or Modified line completes in the same cycle and leaves the line Modified with the written data.
- R5: A write to a Shared line stalls and raises an ownership request (bus_req_own=1). A grant moves the line to Exclusive, the held write completes in the next cycle, and the line is left Modified.
- R6: A refusal (bus_refuse with no bus_grant) ends the transaction and leaves the line Shared. A write that is still held raises a new ownership request one cycle later.
- R7: A write to an Invalid line first raises a shared-read request. After the fill, the write proceeds according to the state the line was filled in.
- R8: A read snoop on a Modified line gives wb_valid high in the next cycle, with wb_line and wb_data equal to that line and its data, and moves the line to Shared. A read snoop on an Exclusive line moves it to Shared with no write-back. A read snoop on a Shared or Invalid line changes nothing.
- R9: An invalidate snoop moves any line to Invalid. A Modified line is written back first, with the same pulse timing as in R8.
- R10: Only one bus request is outstanding at a time. While it is pending, core_ready stays low for every request, hits included.
- R11: When a snoop addresses the same line as the core request in the same cycle, core_ready is low in that cycle and the snoop takes effect first.
- R12: When a snoop and a bus response hit the same line in the same cycle, the snoop is applied first and the response second. An ownership grant for a line that the snoop invalidated leaves the line Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Core request present |
| core_write | input | 1 | 1 = write, 0 = read |
| core_line | input | IDX_W | Line index of the core request |
| core_wdata | input | DATA_W | Write data |
| core_ready | output | 1 | Request completes this cycle |
| core_rdata | output | DATA_W | Read data of core_line |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_own | output | 1 | 1 = ownership (invalidate others), 0 = shared read |
| bus_req_line | output | IDX_W | Line of the outstanding request |
| bus_grant | input | 1 | Request acknowledged (with fill data for reads) |
| bus_refuse | input | 1 | Request refused |
| bus_shared | input | 1 | Another cache holds the line (read grants) |
| bus_fill_data | input | DATA_W | Fill data for read grants |
| snoop_valid | input | 1 | Remote snoop present |
| snoop_inv | input | 1 | 1 = invalidate, 0 = read |
| snoop_line | input | IDX_W | Line addressed by the snoop |
| wb_valid | output | 1 | Write-back pulse |
| wb_line | output | IDX_W | Line being written back |
| wb_data | output | DATA_W | Dirty data being written back |

## Verification
The bench builds the block with four lines and 16-bit data. With four lines, one sequence can keep lines in all four states at once. It can also hold a miss pending on one line while the core switches to a hit on another. The narrow data word keeps fill, write and write-back values easy to tell apart. The reference model tracks the same four lines independently. It compares the stall, the request fields, the read data and the write-back pulse on every cycle, including the cycles where a snoop collides with a core request or with a bus response.

// File: rtl/coh_pkg.sv
// Shared types for the line coherence controller.
// Assumes a two-bit state code; the numeric values are relied upon only
// through the enum names.
package coh_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_state_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } req_phase_e;
endpackage

// File: rtl/coh_line_array.sv
// State and data storage for every line, with the per-line next-state rule.
// Order of effects within one cycle: snoop first, then the bus response,
// then a local write. The request sequencer guarantees that a local write
// never targets the line a snoop addresses in the same cycle.
module coh_line_array
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                snp_valid,
    input  logic                                snp_inv,
    input  logic [IDX_W-1:0]                    snp_line,
    input  logic [IDX_W-1:0]                    rsp_line,
    input  logic                                fill_en,
    input  logic                                fill_shared,
    input  logic [DATA_W-1:0]                   fill_data,
    input  logic                                grant_en,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_line,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [NUM_LINES-1:0][1:0]           state_vec,
    output logic [NUM_LINES-1:0][DATA_W-1:0]    data_vec
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_e       cur_st;
        line_state_e       nxt_st;
        logic [DATA_W-1:0] cur_dat;
        logic [DATA_W-1:0] nxt_dat;
        logic              snp_here;
        logic              rsp_here;
        logic              wr_here;

        assign snp_here = snp_valid && (snp_line == IDX_W'(g));
        assign rsp_here = rsp_line == IDX_W'(g);
        assign wr_here  = wr_en && (wr_line == IDX_W'(g));

        // Next state: snoop effect, then response, then local write.
        always_comb begin
            nxt_st = cur_st;
            if (snp_here) begin
                if (snp_inv)
                    nxt_st = LS_INV;
                else if (cur_st == LS_MOD || cur_st == LS_EXC)
                    nxt_st = LS_SHR;
            end
            if (fill_en && rsp_here)
                nxt_st = fill_shared ? LS_SHR : LS_EXC;
            else if (grant_en && rsp_here && nxt_st == LS_SHR)
                nxt_st = LS_EXC;
            if (wr_here)
                nxt_st = LS_MOD;
        end

        // Next data: a fill or a local write replaces the line contents.
        always_comb begin
            nxt_dat = cur_dat;
            if (fill_en && rsp_here)
                nxt_dat = fill_data;
            else if (wr_here)
                nxt_dat = wr_data;
        end

        // Line registers with synchronous reset to Invalid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_st  <= LS_INV;
                cur_dat <= '0;
            end else begin
                cur_st  <= nxt_st;
                cur_dat <= nxt_dat;
            end
        end

        assign state_vec[g] = cur_st;
        assign data_vec[g]  = cur_dat;
    end

endmodule

// File: rtl/coh_snoop_wb.sv
// Write-back generator: registers a one-cycle pulse carrying the index and
// data of a Modified line that any snoop hits. Assumes at most one snoop
// per cycle.
module coh_snoop_wb
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                snp_valid,
    input  logic [IDX_W-1:0]                    snp_line,
    input  logic [NUM_LINES-1:0][1:0]           state_vec,
    input  logic [NUM_LINES-1:0][DATA_W-1:0]    data_vec,
    output logic                                wb_valid,
    output logic [IDX_W-1:0]                    wb_line,
    output logic [DATA_W-1:0]                   wb_data
);

    logic dirty_hit;

    // Snoop lands on a dirty line this cycle.
    assign dirty_hit = snp_valid && (line_state_e'(state_vec[snp_line]) == LS_MOD);

    // Capture the write-back pulse and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_line  <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= dirty_hit;
            if (dirty_hit) begin
                wb_line <= snp_line;
                wb_data <= data_vec[snp_line];
            end
        end
    end

endmodule

// File: rtl/coh_req_fsm.sv
// Core-side sequencer: decides hits, stalls the core, and keeps the single
// outstanding bus request until a grant or a refusal arrives. Assumes the
// bus answers only while a request is outstanding; a grant beats a
// simultaneous refusal.
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic              core_write,
    input  logic [IDX_W-1:0]  core_line,
    input  line_state_e       cur_state,
    input  logic              snoop_clash,
    input  logic              bus_grant,
    input  logic              bus_refuse,
    output logic              core_ready,
    output logic              wr_en,
    output logic              bus_req_valid,
    output logic              bus_req_own,
    output logic [IDX_W-1:0]  bus_req_line,
    output logic              fill_en,
    output logic              grant_en
);

    req_phase_e phase;
    logic       hit;
    logic       launch;
    logic       done;

    // Hit rule: reads need any valid state, writes need sole ownership.
    always_comb begin
        if (core_write)
            hit = (cur_state == LS_EXC) || (cur_state == LS_MOD);
        else
            hit = (cur_state != LS_INV);
    end

    assign core_ready = (phase == PH_IDLE) && core_valid && !snoop_clash && hit;
    assign wr_en      = core_ready && core_write;
    assign launch     = (phase == PH_IDLE) && core_valid && !snoop_clash && !hit;
    assign done       = (phase == PH_WAIT) && (bus_grant || bus_refuse);
    assign fill_en    = (phase == PH_WAIT) && bus_grant && !bus_req_own;
    assign grant_en   = (phase == PH_WAIT) && bus_grant && bus_req_own;
    assign bus_req_valid = (phase == PH_WAIT);

    // Request phase and the latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            bus_req_own  <= 1'b0;
            bus_req_line <= '0;
        end else if (launch) begin
            phase        <= PH_WAIT;
            bus_req_own  <= core_write && (cur_state == LS_SHR);
            bus_req_line <= core_line;
        end else if (done) begin
            phase        <= PH_IDLE;
        end
    end

endmodule

// File: rtl/coh_line_ctrl.sv
// Top of the line coherence controller: ties the sequencer, the line
// storage and the write-back generator together. Assumes the core holds
// its request until core_ready and that one snoop arrives per cycle at most.
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic              core_write,
    input  logic [IDX_W-1:0]  core_line,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic [DATA_W-1:0] core_rdata,
    output logic              bus_req_valid,
    output logic              bus_req_own,
    output logic [IDX_W-1:0]  bus_req_line,
    input  logic              bus_grant,
    input  logic              bus_refuse,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snoop_valid,
    input  logic              snoop_inv,
    input  logic [IDX_W-1:0]  snoop_line,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_line,
    output logic [DATA_W-1:0] wb_data
);

    logic [NUM_LINES-1:0][1:0]        state_vec;
    logic [NUM_LINES-1:0][DATA_W-1:0] data_vec;
    line_state_e                      cur_state;
    logic                             snoop_clash;
    logic                             wr_en;
    logic                             fill_en;
    logic                             grant_en;

    assign cur_state   = line_state_e'(state_vec[core_line]);
    assign snoop_clash = snoop_valid && (snoop_line == core_line);
    assign core_rdata  = data_vec[core_line];

    coh_req_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_valid    (core_valid),
        .core_write    (core_write),
        .core_line     (core_line),
        .cur_state     (cur_state),
        .snoop_clash   (snoop_clash),
        .bus_grant     (bus_grant),
        .bus_refuse    (bus_refuse),
        .core_ready    (core_ready),
        .wr_en         (wr_en),
        .bus_req_valid (bus_req_valid),
        .bus_req_own   (bus_req_own),
        .bus_req_line  (bus_req_line),
        .fill_en       (fill_en),
        .grant_en      (grant_en)
    );

    coh_line_array #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_valid   (snoop_valid),
        .snp_inv     (snoop_inv),
        .snp_line    (snoop_line),
        .rsp_line    (bus_req_line),
        .fill_en     (fill_en),
        .fill_shared (bus_shared),
        .fill_data   (bus_fill_data),
        .grant_en    (grant_en),
        .wr_en       (wr_en),
        .wr_line     (core_line),
        .wr_data     (core_wdata),
        .state_vec   (state_vec),
        .data_vec    (data_vec)
    );

    coh_snoop_wb #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snoop_valid),
        .snp_line  (snoop_line),
        .state_vec (state_vec),
        .data_vec  (data_vec),
        .wb_valid  (wb_valid),
        .wb_line   (wb_line),
        .wb_data   (wb_data)
    );

endmodule

// File: rtl/coh_line_ctrl_chk.sv
// Protocol checker for the line coherence controller, bound to the top.
// Observes ports only.
module coh_line_ctrl_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_valid,
    input logic [IDX_W-1:0] core_line,
    input logic             core_ready,
    input logic             bus_req_valid,
    input logic             bus_req_own,
    input logic [IDX_W-1:0] bus_req_line,
    input logic             bus_grant,
    input logic             bus_refuse,
    input logic             snoop_valid,
    input logic [IDX_W-1:0] snoop_line,
    input logic             wb_valid,
    input logic [IDX_W-1:0] wb_line
);

    // R3: an unanswered request keeps its fields.
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_grant && !bus_refuse |=>
            bus_req_valid && $stable(bus_req_line) && $stable(bus_req_own));

    // R5: a grant closes the outstanding request.
    assert_grant_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_grant |=> !bus_req_valid);

    // R6: a refusal closes the outstanding request.
    assert_refuse_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_refuse |=> !bus_req_valid);

    // R8: a write-back pulse follows a snoop to the same line.
    assert_wb_follows_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(snoop_valid) && (wb_line == $past(snoop_line)));

    // R10: no completion while a request is pending.
    assert_stall_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !core_ready);

    // R11: a same-line snoop stalls the core for that cycle.
    assert_snoop_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid && core_valid && (snoop_line == core_line) |-> !core_ready);

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_valid    (core_valid),
    .core_line     (core_line),
    .core_ready    (core_ready),
    .bus_req_valid (bus_req_valid),
    .bus_req_own   (bus_req_own),
    .bus_req_line  (bus_req_line),
    .bus_grant     (bus_grant),
    .bus_refuse    (bus_refuse),
    .snoop_valid   (snoop_valid),
    .snoop_line    (snoop_line),
    .wb_valid      (wb_valid),
    .wb_line       (wb_line)
);

// File: tb/test_coh_line_ctrl.sv
// Bench: behavioural reference model stepped once per clock and compared
// with the design's outputs in the middle of the low clock phase.
module test_coh_line_ctrl;
    localparam int NL = 4;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam int HALF = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_valid = 1'b0, core_write = 1'b0;
    logic [IW-1:0] core_line = '0;
    logic [DW-1:0] core_wdata = '0;
    logic          core_ready;
    logic [DW-1:0] core_rdata;
    logic          bus_req_valid, bus_req_own;
    logic [IW-1:0] bus_req_line;
    logic          bus_grant = 1'b0, bus_refuse = 1'b0, bus_shared = 1'b0;
    logic [DW-1:0] bus_fill_data = '0;
    logic          snoop_valid = 1'b0, snoop_inv = 1'b0;
    logic [IW-1:0] snoop_line = '0;
    logic          wb_valid;
    logic [IW-1:0] wb_line;
    logic [DW-1:0] wb_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.
    int            m_st  [NL];
    logic [DW-1:0] m_dat [NL];
    bit            m_pend, m_own, m_wb;
    int            m_line, m_wbl;
    logic [DW-1:0] m_wbd;

    always #HALF clk = ~clk;

    coh_line_ctrl #(.NUM_LINES(NL), .DATA_W(DW)) i_coh_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_write(core_write), .core_line(core_line),
        .core_wdata(core_wdata), .core_ready(core_ready), .core_rdata(core_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_own(bus_req_own), .bus_req_line(bus_req_line),
        .bus_grant(bus_grant), .bus_refuse(bus_refuse), .bus_shared(bus_shared),
        .bus_fill_data(bus_fill_data),
        .snoop_valid(snoop_valid), .snoop_inv(snoop_inv), .snoop_line(snoop_line),
        .wb_valid(wb_valid), .wb_line(wb_line), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic core(input bit v, input bit w, input int l, input logic [DW-1:0] d);
        core_valid = v; core_write = w; core_line = IW'(l); core_wdata = d;
    endtask

    task automatic snoop(input bit v, input bit inv, input int l);
        snoop_valid = v; snoop_inv = inv; snoop_line = IW'(l);
    endtask

    task automatic resp(input bit g, input bit r, input bit sh, input logic [DW-1:0] fd);
        bus_grant = g; bus_refuse = r; bus_shared = sh; bus_fill_data = fd;
    endtask

    // Compare outputs with the model, then advance both by one clock.
    task automatic tick(input string req);
        int  cl = int'(core_line);
        int  sl = int'(snoop_line);
        bit  clash, hit, e_ready, launch;
        int  ns [NL];
        #(HALF/2);
        clash   = snoop_valid && (sl == cl);
        hit     = core_write ? (m_st[cl] >= 2) : (m_st[cl] != 0);
        e_ready = !m_pend && core_valid && !clash && hit;
        launch  = !m_pend && core_valid && !clash && !hit;
        chk(core_ready == e_ready, req, "core_ready", core_ready, e_ready);
        chk(bus_req_valid == m_pend, req, "bus_req_valid", bus_req_valid, m_pend);
        if (m_pend) begin
            chk(bus_req_own == m_own, req, "bus_req_own", bus_req_own, m_own);
            chk(int'(bus_req_line) == m_line, req, "bus_req_line", bus_req_line, m_line);
        end
        chk(wb_valid == m_wb, req, "wb_valid", wb_valid, m_wb);
        if (m_wb) begin
            chk(int'(wb_line) == m_wbl, req, "wb_line", wb_line, m_wbl);
            chk(wb_data == m_wbd, req, "wb_data", wb_data, m_wbd);
        end
        if (e_ready && !core_write)
            chk(core_rdata == m_dat[cl], req, "core_rdata", core_rdata, m_dat[cl]);
        @(posedge clk);
        foreach (ns[i]) ns[i] = m_st[i];
        m_wb = 0;
        if (snoop_valid) begin
            if (m_st[sl] == 3) begin
                m_wb = 1; m_wbl = sl; m_wbd = m_dat[sl];
            end
            if (snoop_inv) ns[sl] = 0;
            else if (m_st[sl] >= 2) ns[sl] = 1;
        end
        if (m_pend && (bus_grant || bus_refuse)) begin
            m_pend = 0;
            if (bus_grant) begin
                if (!m_own) begin
                    ns[m_line] = bus_shared ? 1 : 2;
                    m_dat[m_line] = bus_fill_data;
                end else if (ns[m_line] == 1) begin
                    ns[m_line] = 2;
                end
            end
        end
        if (e_ready && core_write) begin
            ns[cl] = 3; m_dat[cl] = core_wdata;
        end
        if (launch) begin
            m_pend = 1; m_own = core_write && (m_st[cl] == 1); m_line = cl;
        end
        foreach (ns[i]) m_st[i] = ns[i];
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(2 * HALF * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        foreach (m_st[i]) begin m_st[i] = 0; m_dat[i] = '0; end
        m_pend = 0; m_own = 0; m_wb = 0; m_line = 0; m_wbl = 0; m_wbd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset, first read misses.
        tick("R1"); tick("R1");
        core(1, 0, 0, 0); tick("R1");
        tick("R3"); tick("R10");
        resp(1, 0, 0, 16'hA11); tick("R3"); resp(0, 0, 0, 0);
        tick("R2");
        // R4: write hit on Exclusive, read back.
        core(1, 1, 0, 16'hB22); tick("R4");
        core(1, 0, 0, 0); tick("R4");
        // R8: read snoop on Modified.
        core(0, 0, 0, 0); snoop(1, 0, 0); tick("R8"); snoop(0, 0, 0); tick("R8");
        core(1, 0, 0, 0); tick("R2"); tick("R2");
        // R5/R6: upgrade refused, retried, granted.
        core(1, 1, 0, 16'hC33); tick("R5"); tick("R5");
        resp(0, 1, 0, 0); tick("R6"); resp(0, 0, 0, 0); tick("R6"); tick("R6");
        resp(1, 0, 0, 0); tick("R5"); resp(0, 0, 0, 0); tick("R5");
        core(0, 0, 0, 0);
        // R9: invalidate snoop on Modified.
        snoop(1, 1, 0); tick("R9"); snoop(0, 0, 0); tick("R9");
        core(1, 0, 0, 0); tick("R9"); tick("R3");
        resp(1, 0, 1, 16'h0D44); tick("R3"); resp(0, 0, 0, 0); tick("R3");
        // R7: write to an Invalid line.
        core(1, 1, 1, 16'hE55); tick("R7"); tick("R7");
        resp(1, 0, 0, 16'h1111); tick("R7"); resp(0, 0, 0, 0); tick("R7");
        // R10: a hit on another line is held off while a miss is pending.
        core(1, 0, 2, 0); tick("R10");
        core(1, 0, 1, 0); tick("R10"); tick("R10");
        resp(1, 0, 1, 16'h2222); tick("R10"); resp(0, 0, 0, 0); tick("R2");
        // R11: snoop and write on the same line together.
        core(1, 1, 1, 16'hF66); snoop(1, 0, 1); tick("R11");
        snoop(0, 0, 0); tick("R11"); tick("R11");
        // R12: ownership grant meets an invalidate snoop.
        resp(1, 0, 0, 0); snoop(1, 1, 1); tick("R12");
        resp(0, 0, 0, 0); snoop(0, 0, 0); tick("R12"); tick("R12");
        resp(1, 0, 0, 16'h3333); tick("R7"); resp(0, 0, 0, 0); tick("R7");
        core(0, 0, 0, 0); tick("R7");
        // R8: read snoop on Exclusive gives no write-back.
        core(1, 0, 3, 0); tick("R8"); tick("R8");
        resp(1, 0, 0, 16'h4444); tick("R8"); resp(0, 0, 0, 0);
        core(0, 0, 0, 0); snoop(1, 0, 3); tick("R8"); snoop(0, 0, 0); tick("R8");
        core(1, 1, 3, 16'h5555); tick("R8"); tick("R8");
        resp(1, 0, 0, 0); tick("R5"); resp(0, 0, 0, 0); tick("R5");
        core(0, 0, 0, 0); tick("R5");
        // R9: invalidate snoop on Shared, no write-back, then a miss.
        snoop(1, 1, 2); tick("R9"); snoop(0, 0, 0); tick("R9");
        core(1, 0, 2, 0); tick("R9"); tick("R9");
        resp(1, 0, 0, 16'h0001); tick("R3"); resp(0, 0, 0, 0); tick("R3");
        core(0, 0, 0, 0); tick("R1");
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule